// File: doc/BRIEF.md
# Packed Integer Outer-Product Accumulator Bank

This block holds a bank of square tiles of signed 32-bit integers and updates one tile at a time with the outer product of two packed operand vectors. Each element of the tile is one sum of products. An update command names a tile and supplies two 128-bit vectors, X and Y. It also selects how each 32-bit row of those vectors is split into signed sub-elements: two 16-bit values, four 8-bit values or eight 4-bit values. Element (i,j) of the product is the dot product of row i of X with row j of Y, so the product is a 4x4 tile at every width. The old tile and the product each carry their own negate control. A further control treats the old tile as zero, which turns the update into a plain product load.

Tiles are loaded from, and read back as, four 128-bit words on a 512-bit bus. Commands are accepted one at a time through a valid/ready handshake. An update takes two cycles. The bank refuses a new command during the second cycle, so a read of the same tile issued right after an update returns the new values. A read-out answers with a one-cycle response pulse.

Top module: `mxacc_array`

## Requirements
- R1: After the asynchronous reset (rst_n low), every tile reads back as all zeros, cmd_ready is 1 and rsp_valid is 0.
- R2: Opcode 1 (load) writes cmd_data into tile cmd_idx, and opcode 2 (read) returns that tile on rsp_data with rsp_valid high for exactly the cycle after acceptance. Element (i,j) sits at bits [128i+32j+31 : 128i+32j].
- R3: Opcode 0 (update) with width code 0 splits each 32-bit row into two signed 16-bit sub-elements, sub-element s at bits [16s+15:16s]. Product element (i,j) is the sum over s of X row i sub s times Y row j sub s, where row r is bits [32r+31:32r].
- R4: Width code 1 splits each row into four signed 8-bit sub-elements, sub-element s at bits [8s+7:8s], and forms the product in the same way.
- R5: Width codes 2 and 3 split each row into eight signed 4-bit sub-elements, sub-element s at bits [4s+3:4s], and form the product in the same way.
- R6: The update result is (neg_acc ? -A : A) + (neg_prod ? -P : P), where A is the old tile and P is the product. The result is written back into the same tile.
- R7: With cmd_zero_acc set, A is taken as zero, so the result is ±P whatever the old tile holds and whatever neg_acc is.
- R8: All arithmetic wraps modulo 2^32, with no saturation.
- R9: After an update is accepted, cmd_ready is 0 for exactly one cycle. A read accepted at the first opportunity after that returns the updated tile.
- R10: An update or a load changes only the selected tile; the other tiles keep their contents.
- R11: Opcode 3 is accepted but changes no tile and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 update, 1 load, 2 read, 3 no operation |
| cmd_idx | input | 3 | Tile index |
| cmd_width | input | 2 | Sub-element width: 0 int16, 1 int8, 2 or 3 int4 |
| cmd_neg_acc | input | 1 | Negate the old tile |
| cmd_neg_prod | input | 1 | Negate the product |
| cmd_zero_acc | input | 1 | Treat the old tile as zero |
| cmd_x | input | 128 | Operand X, four 32-bit rows |
| cmd_y | input | 128 | Operand Y, four 32-bit rows |
| cmd_data | input | 512 | Tile contents for a load |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 512 | Tile contents returned by a read |

## Verification
The assertions take for granted that the command fields carry known values whenever cmd_valid is high. They also assume that reset is applied from time zero, before the first command. The stall and write-back properties further assume that the source never counts a command as taken while cmd_ready is low. The stimulus meets these assumptions in three ways: it changes inputs only on the falling clock edge, it holds every command until it sees cmd_ready, and it drops cmd_valid once the command has been accepted. Sign and wrap corners are forced deliberately with extreme operand and tile values, in a mix with pseudo-random commands.

// File: rtl/mxacc_pkg.sv
package mxacc_pkg;

   typedef enum logic [1:0] {
      OP_UPDATE    = 2'd0,
      OP_MOVE_TO   = 2'd1,
      OP_MOVE_FROM = 2'd2,
      OP_NOP       = 2'd3
   } mx_op_e;

   typedef enum logic [1:0] {
      W_I16  = 2'd0,
      W_I8   = 2'd1,
      W_I4   = 2'd2,
      W_I4_B = 2'd3
   } mx_width_e;

endpackage

// File: rtl/mxacc_lanes.sv
module mxacc_lanes #(
   parameter int SW = 16,
   parameter int EW = 32
) (
   input  logic [EW-1:0] a_i,
   input  logic [EW-1:0] b_i,
   output logic [EW-1:0] sum_o
);
   localparam int N  = EW / SW;
   localparam int PW = 2 * SW;

   generate
      if (EW % SW != 0 || PW > EW) begin : g_bad_cfg
         $error("mxacc_lanes: SW must divide EW and 2*SW must fit in EW");
      end
   endgenerate

   logic signed [PW-1:0] prod [N];

   for (genvar g = 0; g < N; g++) begin : g_lane
      logic signed [PW-1:0] ea;
      logic signed [PW-1:0] eb;
      assign ea = PW'($signed(a_i[g*SW +: SW]));
      assign eb = PW'($signed(b_i[g*SW +: SW]));
      assign prod[g] = ea * eb;
   end

   logic signed [EW-1:0] acc;
   always_comb begin
      acc = '0;
      for (int g = 0; g < N; g++) begin
         acc = acc + EW'(prod[g]);
      end
   end

   assign sum_o = acc;

endmodule

// File: rtl/mxacc_dot.sv
module mxacc_dot
   import mxacc_pkg::*;
#(
   parameter int EW = 32
) (
   input  logic [EW-1:0] x_row_i,
   input  logic [EW-1:0] y_row_i,
   input  logic [1:0]    width_i,
   output logic [EW-1:0] dot_o
);
   generate
      if (EW % 16 != 0) begin : g_bad_ew
         $error("mxacc_dot: EW must be a multiple of 16");
      end
   endgenerate

   logic [EW-1:0] sum16, sum8, sum4;

   mxacc_lanes #(.SW(16), .EW(EW)) u_l16 (.a_i(x_row_i), .b_i(y_row_i), .sum_o(sum16));
   mxacc_lanes #(.SW(8),  .EW(EW)) u_l8  (.a_i(x_row_i), .b_i(y_row_i), .sum_o(sum8));
   mxacc_lanes #(.SW(4),  .EW(EW)) u_l4  (.a_i(x_row_i), .b_i(y_row_i), .sum_o(sum4));

   always_comb begin
      unique case (mx_width_e'(width_i))
         W_I16:   dot_o = sum16;
         W_I8:    dot_o = sum8;
         default: dot_o = sum4;
      endcase
   end

   always_comb begin
      if (x_row_i == '0) begin
         AST_DOT_ZERO: assert (dot_o == '0); // R3
      end
   end

endmodule

// File: rtl/mxacc_bank.sv
module mxacc_bank #(
   parameter int N_ACC = 8,
   parameter int ACC_W = 512,
   parameter int IDX_W = $clog2(N_ACC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [ACC_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [ACC_W-1:0] rd_data_o
);
   generate
      if (N_ACC < 2 || (1 << IDX_W) < N_ACC) begin : g_bad_cfg
         $error("mxacc_bank: index width too small for tile count");
      end
   endgenerate

   logic [ACC_W-1:0] mem [N_ACC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_ACC; k++) mem[k] <= '0;
      end else if (wr_en_i) begin
         mem[wr_idx_i] <= wr_data_i;
      end
   end

   assign rd_data_o = mem[rd_idx_i];

   AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (mem[$past(wr_idx_i)] == $past(wr_data_i))); // R2

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(rd_data_o) || !$stable(rd_idx_i)); // R10

endmodule

// File: rtl/mxacc_array.sv
module mxacc_array
   import mxacc_pkg::*;
#(
   parameter int N_ACC = 8,
   parameter int DIM   = 4,
   parameter int EW    = 32,
   parameter int IDX_W = $clog2(N_ACC),
   parameter int WORD_W = DIM * EW,
   parameter int ACC_W  = DIM * DIM * EW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [1:0]        cmd_width,
   input  logic              cmd_neg_acc,
   input  logic              cmd_neg_prod,
   input  logic              cmd_zero_acc,
   input  logic [WORD_W-1:0] cmd_x,
   input  logic [WORD_W-1:0] cmd_y,
   input  logic [ACC_W-1:0]  cmd_data,
   output logic              rsp_valid,
   output logic [ACC_W-1:0]  rsp_data
);
   localparam int N_EL = DIM * DIM;

   generate
      if (DIM < 1 || WORD_W != DIM * EW || ACC_W != DIM * WORD_W) begin : g_bad_cfg
         $error("mxacc_array: derived widths are inconsistent");
      end
   endgenerate

   mx_op_e op;
   logic   fire, fire_upd, fire_to, fire_from;
   assign op        = mx_op_e'(cmd_op);
   assign fire      = cmd_valid && cmd_ready;
   assign fire_upd  = fire && (op == OP_UPDATE);
   assign fire_to   = fire && (op == OP_MOVE_TO);
   assign fire_from = fire && (op == OP_MOVE_FROM);

   // Product tile, one dot engine per element
   logic [ACC_W-1:0] prod_w;
   for (genvar i = 0; i < DIM; i++) begin : g_row
      for (genvar j = 0; j < DIM; j++) begin : g_col
         mxacc_dot #(.EW(EW)) u_dot (
            .x_row_i (cmd_x[i*EW +: EW]),
            .y_row_i (cmd_y[j*EW +: EW]),
            .width_i (cmd_width),
            .dot_o   (prod_w[(i*DIM+j)*EW +: EW])
         );
      end
   end

   // Stage one: captured product and controls
   logic             s1_v;
   logic [IDX_W-1:0] s1_idx;
   logic [ACC_W-1:0] s1_prod;
   logic             s1_neg_acc, s1_neg_prod, s1_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v        <= 1'b0;
         s1_idx      <= '0;
         s1_prod     <= '0;
         s1_neg_acc  <= 1'b0;
         s1_neg_prod <= 1'b0;
         s1_zero     <= 1'b0;
      end else begin
         s1_v <= fire_upd;
         if (fire_upd) begin
            s1_idx      <= cmd_idx;
            s1_prod     <= prod_w;
            s1_neg_acc  <= cmd_neg_acc;
            s1_neg_prod <= cmd_neg_prod;
            s1_zero     <= cmd_zero_acc;
         end
      end
   end

   assign cmd_ready = !s1_v;

   // Stage two: combine with old tile and write back
   logic [IDX_W-1:0] rd_idx;
   logic [ACC_W-1:0] rd_data;
   logic [ACC_W-1:0] upd_data;
   assign rd_idx = s1_v ? s1_idx : cmd_idx;

   for (genvar e = 0; e < N_EL; e++) begin : g_el
      logic signed [EW-1:0] a_old, a_term, p_raw, p_term;
      assign a_old  = rd_data[e*EW +: EW];
      assign p_raw  = s1_prod[e*EW +: EW];
      assign a_term = s1_zero ? '0 : (s1_neg_acc ? -a_old : a_old);
      assign p_term = s1_neg_prod ? -p_raw : p_raw;
      assign upd_data[e*EW +: EW] = a_term + p_term;
   end

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [ACC_W-1:0] wr_data;
   assign wr_en   = s1_v || fire_to;
   assign wr_idx  = s1_v ? s1_idx : cmd_idx;
   assign wr_data = s1_v ? upd_data : cmd_data;

   mxacc_bank #(.N_ACC(N_ACC), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .rd_idx_i  (rd_idx),
      .rd_data_o (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= fire_from;
         if (fire_from) rsp_data <= rd_data;
      end
   end

   AST_UPD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      fire_upd |=> !cmd_ready); // R9

   AST_UPD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> cmd_ready); // R9

   AST_UPD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_upd |=> (wr_en && wr_idx == $past(cmd_idx))); // R6

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_from |=> rsp_valid); // R2

   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_from |=> !rsp_valid); // R11

   AST_NOP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_NOP) |=> !s1_v); // R11

endmodule

// File: tb/mxacc_array_tb.sv
module mxacc_array_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [1:0]   cmd_op = 2'd3;
   logic [2:0]   cmd_idx = '0;
   logic [1:0]   cmd_width = '0;
   logic         cmd_neg_acc = 1'b0, cmd_neg_prod = 1'b0, cmd_zero_acc = 1'b0;
   logic [127:0] cmd_x = '0, cmd_y = '0;
   logic [511:0] cmd_data = '0;
   logic         rsp_valid;
   logic [511:0] rsp_data;

   mxacc_array dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_width(cmd_width),
      .cmd_neg_acc(cmd_neg_acc), .cmd_neg_prod(cmd_neg_prod), .cmd_zero_acc(cmd_zero_acc),
      .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_data(cmd_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // Reference model
   int           m_acc [8][16];
   bit           pend;
   int           pend_idx;
   int           pend_val [16];
   bit           exp_rv;
   logic [511:0] exp_rd;

   function automatic int dot_ref(logic [31:0] a, logic [31:0] b, int w);
      int n, bits, sum;
      logic signed [31:0] ta, tb;
      n = (w == 0) ? 2 : (w == 1) ? 4 : 8;
      bits = 32 / n;
      sum = 0;
      for (int s = 0; s < n; s++) begin
         ta = a << (32 - bits*(s+1));
         ta = ta >>> (32 - bits);
         tb = b << (32 - bits*(s+1));
         tb = tb >>> (32 - bits);
         sum += ta * tb;
      end
      return sum;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < 8; t++) for (int e = 0; e < 16; e++) m_acc[t][e] = 0;
         pend = 1'b0; exp_rv = 1'b0; exp_rd = '0;
      end else begin
         exp_rv = 1'b0;
         if (pend) begin
            for (int e = 0; e < 16; e++) m_acc[pend_idx][e] = pend_val[e];
            pend = 1'b0;
         end else if (cmd_valid) begin
            case (cmd_op)
               2'd0: begin
                  for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) begin
                     int p, a;
                     p = dot_ref(cmd_x[i*32 +: 32], cmd_y[j*32 +: 32], int'(cmd_width));
                     a = cmd_zero_acc ? 0 : (cmd_neg_acc ? -m_acc[cmd_idx][i*4+j] : m_acc[cmd_idx][i*4+j]);
                     pend_val[i*4+j] = a + (cmd_neg_prod ? -p : p);
                  end
                  pend_idx = int'(cmd_idx);
                  pend = 1'b1;
               end
               2'd1: for (int e = 0; e < 16; e++) m_acc[cmd_idx][e] = int'(cmd_data[e*32 +: 32]);
               2'd2: begin
                  exp_rv = 1'b1;
                  for (int e = 0; e < 16; e++) exp_rd[e*32 +: 32] = m_acc[cmd_idx][e];
               end
               default: ;
            endcase
         end
      end
   end

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         bit bad;
         bad = 1'b0;
         n_cmp++;
         if (cmd_ready !== !pend) begin
            $display("FAIL %s cycle %0d cmd_ready actual %b expected %b", cur_req, cyc, cmd_ready, !pend);
            bad = 1'b1;
         end
         if (rsp_valid !== exp_rv) begin
            $display("FAIL %s cycle %0d rsp_valid actual %b expected %b", cur_req, cyc, rsp_valid, exp_rv);
            bad = 1'b1;
         end
         if (exp_rv && rsp_data !== exp_rd) begin
            $display("FAIL %s cycle %0d rsp_data actual %h expected %h", cur_req, cyc, rsp_data, exp_rd);
            bad = 1'b1;
         end
         if (bad) n_bad++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog cycle %0d actual hung expected finished", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // Caller is at a falling edge; returns at a falling edge
   task automatic issue(input logic [1:0] op, input int idx, input logic [1:0] w,
                        input bit na, input bit np, input bit za,
                        input logic [127:0] x, input logic [127:0] y, input logic [511:0] d);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = 3'(idx); cmd_width = w;
      cmd_neg_acc = na; cmd_neg_prod = np; cmd_zero_acc = za;
      cmd_x = x; cmd_y = y; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_tile(input int idx);
      issue(2'd2, idx, 2'd0, 0, 0, 0, '0, '0, '0);
   endtask

   task automatic load_tile(input int idx, input logic [511:0] d);
      issue(2'd1, idx, 2'd0, 0, 0, 0, '0, '0, d);
   endtask

   task automatic upd(input int idx, input logic [1:0] w, input bit na, input bit np, input bit za,
                      input logic [127:0] x, input logic [127:0] y);
      issue(2'd0, idx, w, na, np, za, x, y, '0);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [511:0] rnd512();
      return {rnd128(), rnd128(), rnd128(), rnd128()};
   endfunction

   initial begin
      // R1: reset state is compared while rst_n is low and by reading all tiles
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int t = 0; t < 8; t++) read_tile(t);

      // R2: load and read back, layout per element
      cur_req = "R2";
      load_tile(3, rnd512());
      read_tile(3);
      load_tile(5, {16{32'h8000_0001}});
      read_tile(5);

      // R3: int16 sub-elements, R9: read right after the update
      cur_req = "R3";
      upd(3, 2'd0, 0, 0, 0, {32'h7fff_8000, 32'h0001_ffff, 32'h1234_5678, 32'h8000_8000}, rnd128());
      read_tile(3);
      cur_req = "R4";
      upd(3, 2'd1, 0, 0, 0, {32'h807f_01ff, rnd128()} , {32'h7f80_ff01, rnd128()});
      read_tile(3);
      cur_req = "R5";
      upd(3, 2'd2, 0, 0, 0, {4{32'h8f17_79e0}}, {4{32'h7f88_1e69}});
      read_tile(3);
      upd(3, 2'd3, 0, 0, 0, rnd128(), rnd128());
      read_tile(3);

      // R6: all four sign combinations
      cur_req = "R6";
      for (int c = 0; c < 4; c++) begin
         upd(5, 2'd1, c[0], c[1], 0, rnd128(), rnd128());
         read_tile(5);
      end

      // R7: zero old tile, with and without neg_acc
      cur_req = "R7";
      load_tile(6, rnd512());
      upd(6, 2'd0, 1, 0, 1, rnd128(), rnd128());
      read_tile(6);
      upd(6, 2'd2, 0, 1, 1, rnd128(), rnd128());
      read_tile(6);

      // R8: wrap past the largest positive value
      cur_req = "R8";
      load_tile(2, {16{32'h7fff_ffff}});
      upd(2, 2'd1, 0, 0, 0, {4{32'h7f7f_7f7f}}, {4{32'h7f7f_7f7f}});
      read_tile(2);
      load_tile(2, {16{32'h8000_0000}});
      upd(2, 2'd1, 1, 1, 0, {4{32'h7f7f_7f7f}}, {4{32'h7f7f_7f7f}});
      read_tile(2);

      // R9: back-to-back updates then read
      cur_req = "R9";
      upd(1, 2'd0, 0, 0, 0, rnd128(), rnd128());
      upd(1, 2'd1, 0, 1, 0, rnd128(), rnd128());
      read_tile(1);

      // R10: other tiles untouched
      cur_req = "R10";
      for (int t = 0; t < 8; t++) read_tile(t);

      // R11: no-operation opcode changes nothing and gives no response
      cur_req = "R11";
      issue(2'd3, 4, 2'd1, 1, 1, 0, rnd128(), rnd128(), rnd512());
      issue(2'd3, 3, 2'd0, 0, 0, 1, rnd128(), rnd128(), rnd512());
      read_tile(4);
      read_tile(3);

      // R10: random mix of all commands
      cur_req = "R10";
      for (int n = 0; n < 400; n++) begin
         int sel;
         sel = int'($urandom_range(9, 0));
         if (sel < 5)
            upd(int'($urandom_range(7, 0)), 2'($urandom_range(3, 0)), 1'($urandom), 1'($urandom),
                1'($urandom_range(3, 0) == 0), rnd128(), rnd128());
         else if (sel < 6) load_tile(int'($urandom_range(7, 0)), rnd512());
         else if (sel < 9) read_tile(int'($urandom_range(7, 0)));
         else issue(2'd3, int'($urandom_range(7, 0)), 2'd0, 0, 0, 0, rnd128(), rnd128(), rnd512());
      end
      for (int t = 0; t < 8; t++) read_tile(t);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule